// File: doc/BRIEF.md
# SDRAM Open-Page Command Sequencer

This block sits between an internal bus and a bank of SDRAM devices split into several chip-select regions. It takes one read or write request at a time and turns it into the shortest legal command sequence for the current page state. Each chip-select region may hold at most one open row. For every request the block compares the target bank and row with that region's open row and sorts the request into one of three cases. A page hit goes straight to the access command. A region with no open row gets an activate followed by the access. A region with a different row open gets a single-bank precharge first, then the activate, then the access.

Three down-counters enforce the minimum spacing between commands. The first runs from precharge or refresh until the next activate, the second from activate until the next read or write, and the third from write until the next precharge. Each counter loads from its own configuration input when its command is issued. A refresh request takes priority over bus requests. It closes every open row with a precharge-all sent to all regions, then sends the refresh to all regions.

All command pins are registered. A command chosen in one cycle appears on the pins in the next cycle. The acknowledge outputs are combinational and mark the cycle in which the access or refresh is chosen.

Top module: `sdram_page_sequencer`

## Requirements
- R1: While reset is held low, sd_cke is 0, every sd_cs_n bit is 1, sd_ras_n, sd_cas_n and sd_we_n are 1, and req_ack and ref_ack are 0.
- R2: The command is coded on {sd_ras_n,sd_cas_n,sd_we_n} as follows: activate 011, read 101, write 100, precharge 010, refresh 001. In a cycle with no command every sd_cs_n bit is 1 and the code is 111. A command to one region drives only that region's sd_cs_n bit low, and bit i belongs to region i.
- R3: A request to a region with no open row issues an activate, with sd_ba equal to the bank and sd_addr equal to the row. It then issues the access, with sd_ba equal to the bank, sd_addr equal to the column, and sd_addr[10] equal to 0.
- R4: A request whose bank and row match the region's open row issues only the read or write command, with no activate.
- R5: A request to a region whose open row differs in row or bank first issues a precharge. That precharge carries sd_ba equal to the currently open bank and sd_addr equal to 0, so sd_addr[10] is 0. The activate for the new row and then the access follow.
- R6: Each region keeps its own open row. Activating a row in one region does not change whether a request to another region is a hit.
- R7: A read or write follows the preceding activate by at least cfg_trcd+1 cycles, and by exactly that many when nothing else blocks it.
- R8: An activate or refresh follows the preceding precharge or refresh by at least cfg_trp+1 cycles, and by exactly that many when nothing else blocks it.
- R9: A precharge of either kind follows the preceding write by at least cfg_twr+1 cycles, and by exactly that many when nothing else blocks it.
- R10: When ref_req is high, it wins over a pending bus request. The block issues a precharge-all with all sd_cs_n bits low and sd_addr equal to 0x400 (only bit 10 set), then a refresh with all sd_cs_n bits low. After that no row is open, so the next bus request starts with an activate.
- R11: req_ack is high in the cycle just before the read or write appears on the pins, and ref_ack is high in the cycle just before the refresh appears on the pins.
- R12: sd_cke goes to 1 on the first clock edge after reset is released and stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_trp | input | GAP_W | Cycles to wait after precharge or refresh before activate or refresh |
| cfg_trcd | input | GAP_W | Cycles to wait after activate before read or write |
| cfg_twr | input | GAP_W | Cycles to wait after write before precharge |
| req_valid | input | 1 | Bus request pending, held until req_ack |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | $clog2(NUM_CS) | Target chip-select region |
| req_bank | input | $clog2(NUM_BANK) | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ack | output | 1 | Access command chosen this cycle |
| ref_req | input | 1 | Refresh request, held until ref_ack |
| ref_ack | output | 1 | Refresh command chosen this cycle |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | NUM_CS | Per-region chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | $clog2(NUM_BANK) | Bank address |
| sd_addr | output | ADDR_W | Row, column or precharge-select address |

## Verification
The assertions assume that a requester keeps req_valid and its fields steady until req_ack, and drops the request in the cycle after. They assume the same for ref_req and ref_ack. They also assume that req_cs names an existing region and that the configuration inputs change only while no spacing counter is running. The bench drives every input on the falling edge. Each request task holds its fields until it sees the acknowledge, then clears or replaces them at the next falling edge. The bench changes the spacing values only after all traffic has drained.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM page sequencer.
// Assumes the command code is the active-low triple {ras_n, cas_n, we_n}.
package sdram_seq_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE = 3'b111,
        CMD_ACT  = 3'b011,
        CMD_RD   = 3'b101,
        CMD_WR   = 3'b100,
        CMD_PRE  = 3'b010,
        CMD_REF  = 3'b001
    } sd_cmd_e;

    typedef enum logic [1:0] {
        PG_HIT,
        PG_IDLE,
        PG_MISS
    } page_cls_e;

    localparam int unsigned A10_BIT = 10;
endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that enforces a minimum spacing after a command.
// Loads load_val on load and counts down to zero; busy while non-zero.
// Assumes load is a single-cycle pulse from the issuer.
module sdram_gap_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    // Load on command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R7 R8 R9
    gap_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sdram_row_tracker.sv
// Holds the single open row of one chip-select region.
// Assumes open_en and close_en are never high together.
module sdram_row_tracker #(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic [BANK_W-1:0] open_bank,
    input  logic [ROW_W-1:0]  open_row,
    output logic              is_open,
    output logic [BANK_W-1:0] cur_bank,
    output logic [ROW_W-1:0]  cur_row
);
    // Record the row on activate, forget it on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            cur_bank <= '0;
            cur_row  <= '0;
        end else if (close_en) begin
            is_open  <= 1'b0;
        end else if (open_en) begin
            is_open  <= 1'b1;
            cur_bank <= open_bank;
            cur_row  <= open_row;
        end
    end

    // R5
    close_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |=> !is_open);

    // R3
    open_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_en && !close_en) |=> (is_open && cur_row == $past(open_row)
                                    && cur_bank == $past(open_bank)));
endmodule

// File: rtl/sdram_cmd_issuer.sv
// Chooses one SDRAM command per cycle from the request, the page state
// and the spacing timers, and registers it onto the pins.
// Assumes requests are held until acknowledged.
module sdram_cmd_issuer
    import sdram_seq_pkg::*;
#(
    parameter int unsigned NUM_CS = 2,
    parameter int unsigned CS_W   = 1,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned ADDR_W = 13
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [CS_W-1:0]                req_cs,
    input  logic [BANK_W-1:0]              req_bank,
    input  logic [ROW_W-1:0]               req_row,
    input  logic [COL_W-1:0]               req_col,
    output logic                           req_ack,
    input  logic                           ref_req,
    output logic                           ref_ack,
    input  logic [NUM_CS-1:0]              trk_vld,
    input  logic [NUM_CS-1:0][BANK_W-1:0]  trk_bank,
    input  logic [NUM_CS-1:0][ROW_W-1:0]   trk_row,
    output logic [NUM_CS-1:0]              trk_open,
    output logic [NUM_CS-1:0]              trk_close,
    input  logic                           trp_busy,
    input  logic                           trcd_busy,
    input  logic                           twr_busy,
    output logic                           trp_load,
    output logic                           trcd_load,
    output logic                           twr_load,
    output logic                           sd_cke,
    output logic [NUM_CS-1:0]              sd_cs_n,
    output logic                           sd_ras_n,
    output logic                           sd_cas_n,
    output logic                           sd_we_n,
    output logic [BANK_W-1:0]              sd_ba,
    output logic [ADDR_W-1:0]              sd_addr
);
    typedef enum logic {ST_RUN, ST_REF} st_e;

    st_e              st_q, st_d;
    page_cls_e        cls;
    logic             sel_vld;
    logic [BANK_W-1:0] sel_bank;
    logic [ROW_W-1:0] sel_row;
    sd_cmd_e          nxt_cmd;
    logic             nxt_all;
    logic [BANK_W-1:0] nxt_ba;
    logic [ADDR_W-1:0] nxt_addr;
    logic [NUM_CS-1:0] nxt_cs_n;

    // Sort the request against the open row of its region.
    always_comb begin
        sel_vld  = trk_vld[req_cs];
        sel_bank = trk_bank[req_cs];
        sel_row  = trk_row[req_cs];
        if (!sel_vld)                                     cls = PG_IDLE;
        else if (sel_bank == req_bank && sel_row == req_row) cls = PG_HIT;
        else                                              cls = PG_MISS;
    end

    // Pick this cycle's command, subject to priority and spacing.
    always_comb begin
        st_d      = st_q;
        nxt_cmd   = CMD_IDLE;
        nxt_all   = 1'b0;
        nxt_ba    = '0;
        nxt_addr  = '0;
        req_ack   = 1'b0;
        ref_ack   = 1'b0;
        trk_open  = '0;
        trk_close = '0;
        trp_load  = 1'b0;
        trcd_load = 1'b0;
        twr_load  = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (ref_req) begin
                    if (!twr_busy) begin
                        nxt_cmd           = CMD_PRE;
                        nxt_all           = 1'b1;
                        nxt_addr[A10_BIT] = 1'b1;
                        trk_close         = '1;
                        trp_load          = 1'b1;
                        st_d              = ST_REF;
                    end
                end else if (req_valid) begin
                    case (cls)
                        PG_HIT: if (!trcd_busy) begin
                            nxt_cmd           = req_write ? CMD_WR : CMD_RD;
                            nxt_ba            = req_bank;
                            nxt_addr          = ADDR_W'(req_col);
                            nxt_addr[A10_BIT] = 1'b0;
                            req_ack           = 1'b1;
                            twr_load          = req_write;
                        end
                        PG_IDLE: if (!trp_busy) begin
                            nxt_cmd          = CMD_ACT;
                            nxt_ba           = req_bank;
                            nxt_addr         = ADDR_W'(req_row);
                            trk_open[req_cs] = 1'b1;
                            trcd_load        = 1'b1;
                        end
                        default: if (!twr_busy) begin
                            nxt_cmd           = CMD_PRE;
                            nxt_ba            = sel_bank;
                            trk_close[req_cs] = 1'b1;
                            trp_load          = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                if (!trp_busy) begin
                    nxt_cmd  = CMD_REF;
                    nxt_all  = 1'b1;
                    ref_ack  = 1'b1;
                    trp_load = 1'b1;
                    st_d     = ST_RUN;
                end
            end
        endcase
    end

    // Route the command to one region, to all regions, or to none.
    always_comb begin
        if (nxt_cmd == CMD_IDLE) nxt_cs_n = '1;
        else if (nxt_all)        nxt_cs_n = '0;
        else                     nxt_cs_n = ~(NUM_CS'(1) << req_cs);
    end

    // Register the state and the pin values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_RUN;
            sd_cke   <= 1'b0;
            sd_cs_n  <= '1;
            sd_ras_n <= 1'b1;
            sd_cas_n <= 1'b1;
            sd_we_n  <= 1'b1;
            sd_ba    <= '0;
            sd_addr  <= '0;
        end else begin
            st_q     <= st_d;
            sd_cke   <= 1'b1;
            sd_cs_n  <= nxt_cs_n;
            {sd_ras_n, sd_cas_n, sd_we_n} <= nxt_cmd;
            sd_ba    <= nxt_ba;
            sd_addr  <= nxt_addr;
        end
    end

    // R12
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    // R2
    rw_one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ras_n && !sd_cas_n) |-> ($countones(~sd_cs_n) == 1));

    // R11
    ack_to_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (sd_ras_n && !sd_cas_n));
endmodule

// File: rtl/sdram_page_sequencer.sv
// Top level: per-region open-row trackers, three spacing timers and
// the command issuer. Assumes NUM_CS >= 2 and COL_W <= 10.
module sdram_page_sequencer #(
    parameter int unsigned NUM_CS   = 2,
    parameter int unsigned NUM_BANK = 4,
    parameter int unsigned ROW_W    = 13,
    parameter int unsigned COL_W    = 10,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned GAP_W    = 4,
    localparam int unsigned CS_W    = $clog2(NUM_CS),
    localparam int unsigned BANK_W  = $clog2(NUM_BANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAP_W-1:0]  cfg_trp,
    input  logic [GAP_W-1:0]  cfg_trcd,
    input  logic [GAP_W-1:0]  cfg_twr,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ack,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic              sd_cke,
    output logic [NUM_CS-1:0] sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);
    logic [NUM_CS-1:0]             trk_vld, trk_open, trk_close;
    logic [NUM_CS-1:0][BANK_W-1:0] trk_bank;
    logic [NUM_CS-1:0][ROW_W-1:0]  trk_row;
    logic trp_busy, trcd_busy, twr_busy;
    logic trp_load, trcd_load, twr_load;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_trk
        sdram_row_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_trk (
            .clk(clk), .rst_n(rst_n),
            .open_en(trk_open[g]), .close_en(trk_close[g]),
            .open_bank(req_bank), .open_row(req_row),
            .is_open(trk_vld[g]), .cur_bank(trk_bank[g]), .cur_row(trk_row[g])
        );

        // R4 R6
        rw_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sd_ras_n && !sd_cas_n && !sd_cs_n[g]) |-> (trk_vld[g] && trk_bank[g] == sd_ba));
    end

    sdram_gap_timer #(.CNT_W(GAP_W)) u_trp (
        .clk(clk), .rst_n(rst_n), .load(trp_load), .load_val(cfg_trp), .busy(trp_busy));
    sdram_gap_timer #(.CNT_W(GAP_W)) u_trcd (
        .clk(clk), .rst_n(rst_n), .load(trcd_load), .load_val(cfg_trcd), .busy(trcd_busy));
    sdram_gap_timer #(.CNT_W(GAP_W)) u_twr (
        .clk(clk), .rst_n(rst_n), .load(twr_load), .load_val(cfg_twr), .busy(twr_busy));

    sdram_cmd_issuer #(
        .NUM_CS(NUM_CS), .CS_W(CS_W), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ack(req_ack), .ref_req(ref_req), .ref_ack(ref_ack),
        .trk_vld(trk_vld), .trk_bank(trk_bank), .trk_row(trk_row),
        .trk_open(trk_open), .trk_close(trk_close),
        .trp_busy(trp_busy), .trcd_busy(trcd_busy), .twr_busy(twr_busy),
        .trp_load(trp_load), .trcd_load(trcd_load), .twr_load(twr_load),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    // R10
    ref_rows_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_ras_n && !sd_cas_n && sd_we_n) |-> (trk_vld == '0));
endmodule

// File: tb/sdram_page_sequencer_tb.sv
module sdram_page_sequencer_tb;
    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001;
    localparam logic [1:0] CS0 = 2'b10, CS1 = 2'b01, CSALL = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_trp = 4'd2, cfg_trcd = 4'd3, cfg_twr = 4'd1;
    logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [0:0] req_cs = '0;
    logic [1:0] req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0] req_col = '0;
    logic req_ack, ref_ack, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0] sd_cs_n, sd_ba;
    logic [12:0] sd_addr;

    int n_chk = 0, n_fail = 0, cyc = 0, lp = 0, ack_cyc = 0;
    logic [19:0] log_e [64];
    int log_c [64];
    bit ref_seen = 1'b0;

    sdram_page_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_ack(req_ack), .ref_req(ref_req),
        .ref_ack(ref_ack), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Log every command seen on the pins.
    always @(negedge clk) begin
        if (rst_n && sd_cs_n != 2'b11 && lp < 64) begin
            log_e[lp] <= {sd_ras_n, sd_cas_n, sd_we_n, sd_cs_n, sd_ba, sd_addr};
            log_c[lp] <= cyc;
            lp <= lp + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] ent(logic [2:0] c, logic [1:0] cs, logic [1:0] ba, logic [12:0] a);
        return {c, cs, ba, a};
    endfunction

    task automatic chk_ent(input int idx, input logic [19:0] exp, input string tag);
        if (idx >= lp) chk(1'b0, tag, -1, int'(exp));
        else chk(log_e[idx] == exp, tag, int'(log_e[idx]), int'(exp));
    endtask

    task automatic chk_gap(input int i, input int gap, input string tag);
        chk(log_c[i+1] - log_c[i] == gap, tag, log_c[i+1] - log_c[i], gap);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Hold a request until acknowledged; leaves fields for the next call.
    task automatic acc(input bit cs, input logic [1:0] bk, input logic [12:0] row,
                       input logic [9:0] col, input bit wr);
        int g = 0;
        req_cs = cs; req_bank = bk; req_row = row; req_col = col; req_write = wr;
        req_valid = 1'b1;
        #1;
        while (!req_ack && g < 200) begin @(negedge clk); #1; g++; end
        if (g >= 200) chk(1'b0, "R11 ack timeout", 0, 1);
        ack_cyc = cyc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ref();
        int g = 0;
        ref_req = 1'b1;
        #1;
        while (!ref_ack && g < 200) begin @(negedge clk); #1; g++; end
        ref_seen = (g < 200);
        @(posedge clk);
        @(negedge clk);
        ref_req = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(sd_cke == 1'b0, "R1 cke in reset", sd_cke, 0);
        chk(sd_cs_n == 2'b11, "R1 cs_n in reset", sd_cs_n, 3);
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 cmd in reset",
            {sd_ras_n, sd_cas_n, sd_we_n}, 7);
        chk(!req_ack && !ref_ack, "R1 acks in reset", {req_ack, ref_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_cke == 1'b1, "R12 cke after reset", sd_cke, 1);
        @(negedge clk);
        chk(sd_cke == 1'b1, "R12 cke stays high", sd_cke, 1);
    endtask

    task automatic t_idle_bank();
        int b = lp;
        acc(1'b0, 2'd1, 13'h55, 10'h12, 1'b0);
        settle();
        chk(lp - b == 2, "R3 command count", lp - b, 2);
        chk_ent(b,   ent(C_ACT, CS0, 2'd1, 13'h055), "R3 R2 activate");
        chk_ent(b+1, ent(C_RD,  CS0, 2'd1, 13'h012), "R3 R2 read");
        chk_gap(b, 4, "R7 act to read");
        chk(log_c[b+1] == ack_cyc + 1, "R11 req_ack timing", log_c[b+1], ack_cyc + 1);
    endtask

    task automatic t_hit();
        int b = lp;
        acc(1'b0, 2'd1, 13'h55, 10'h20, 1'b0);
        acc(1'b0, 2'd1, 13'h55, 10'h21, 1'b1);
        settle();
        chk(lp - b == 2, "R4 no activate on hit", lp - b, 2);
        chk_ent(b,   ent(C_RD, CS0, 2'd1, 13'h020), "R4 hit read");
        chk_ent(b+1, ent(C_WR, CS0, 2'd1, 13'h021), "R4 R2 hit write");
    endtask

    task automatic t_miss();
        int b = lp;
        acc(1'b0, 2'd1, 13'h55, 10'h22, 1'b1);
        acc(1'b0, 2'd2, 13'h77, 10'h05, 1'b0);
        settle();
        chk(lp - b == 4, "R5 command count", lp - b, 4);
        chk_ent(b+1, ent(C_PRE, CS0, 2'd1, 13'h000), "R5 precharge open bank");
        chk_ent(b+2, ent(C_ACT, CS0, 2'd2, 13'h077), "R5 activate new row");
        chk_ent(b+3, ent(C_RD,  CS0, 2'd2, 13'h005), "R5 access");
        chk_gap(b,   2, "R9 write to precharge");
        chk_gap(b+1, 3, "R8 precharge to activate");
        chk_gap(b+2, 4, "R7 activate to read");
    endtask

    task automatic t_regions();
        int b = lp;
        acc(1'b1, 2'd0, 13'h33, 10'h01, 1'b0);
        acc(1'b0, 2'd2, 13'h77, 10'h06, 1'b0);
        settle();
        chk(lp - b == 3, "R6 command count", lp - b, 3);
        chk_ent(b,   ent(C_ACT, CS1, 2'd0, 13'h033), "R6 activate region 1");
        chk_ent(b+1, ent(C_RD,  CS1, 2'd0, 13'h001), "R6 read region 1");
        chk_ent(b+2, ent(C_RD,  CS0, 2'd2, 13'h006), "R6 region 0 still hit");
    endtask

    task automatic t_refresh();
        int b = lp;
        fork
            do_ref();
            acc(1'b0, 2'd2, 13'h77, 10'h07, 1'b0);
        join
        settle();
        chk(ref_seen, "R11 ref_ack seen", ref_seen, 1);
        chk(lp - b == 4, "R10 command count", lp - b, 4);
        chk_ent(b,   ent(C_PRE, CSALL, 2'd0, 13'h400), "R10 precharge all first");
        chk_ent(b+1, ent(C_REF, CSALL, 2'd0, 13'h000), "R10 R2 refresh");
        chk_ent(b+2, ent(C_ACT, CS0, 2'd2, 13'h077), "R10 rows closed");
        chk_ent(b+3, ent(C_RD,  CS0, 2'd2, 13'h007), "R10 access after");
        chk_gap(b,   3, "R8 pall to refresh");
        chk_gap(b+1, 3, "R8 refresh to activate");
    endtask

    task automatic t_zero_gap();
        int b;
        cfg_trp = 4'd0; cfg_trcd = 4'd0;
        @(negedge clk);
        b = lp;
        acc(1'b1, 2'd3, 13'h05, 10'h02, 1'b0);
        acc(1'b1, 2'd3, 13'h06, 10'h03, 1'b0);
        settle();
        chk(lp - b == 5, "R7 command count", lp - b, 5);
        chk_ent(b+2, ent(C_PRE, CS1, 2'd3, 13'h000), "R5 precharge same bank");
        chk_gap(b,   1, "R7 zero trcd");
        chk_gap(b+2, 1, "R8 zero trp");
        chk_gap(b+3, 1, "R7 zero trcd second");
    endtask

    task automatic t_quiet();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(sd_cs_n == 2'b11 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111,
                "R2 idle pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'h1f);
        end
    endtask

    initial begin
        t_reset();
        t_idle_bank();
        t_hit();
        t_miss();
        t_regions();
        t_refresh();
        t_zero_gap();
        t_quiet();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        report();
        $finish;
    end
endmodule